// File: doc/BRIEF.md
# BCD Calendar Clock with Minute Alarm

This block keeps wall-clock time in binary-coded decimal. An internal divider turns the input clock into a once-per-second advance. A chain of counters holds seconds, minutes, 24-hour hours, a one-hot day-of-week, day of month, month and a two-digit year that covers 2000 to 2099. Software sees the time as a small set of byte registers on a plain address/data bus. Writing the seconds register restarts the divider, so the clock can be started on an exact second boundary.

A compare unit holds an alarm minute, hour and date. It is checked only at the moment the minute rolls over. A flag register records an alarm hit, a per-second update and a power-on condition. The power-on flag means the time is not trustworthy until software clears it. One active-low interrupt line combines the alarm and update flags with their enable bits. A read that starts a burst captures all seven time bytes at once. Later bytes of the same burst then come from that capture, so a carry between bytes cannot give a torn value.

Top module: `rtcal_core`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 0x01, date 0x01, month 0x01, year 0x00. The flag register (0x0E) reads 0x01, the alarm bytes and both control bytes read 0x00, and irq_n is high.
- R2: Seconds advance once every TICKS_PER_SEC clock edges. A write to address 0x00 restarts the divider and discards any advance due in that cycle, so the next advance lands exactly TICKS_PER_SEC edges after the write edge.
- R3: Each counter rolls over in BCD and carries into the next one: seconds go from 59 to 00, minutes from 59 to 00, and hours from 23 to 00. Hours are always in 24-hour form.
- R4: The weekday byte (0x03) holds one set bit, bit n for day n with n from 0 to 6. At midnight the set bit moves up by one place, and bit 6 wraps to bit 0.
- R5: The date returns to 01 after the last day of the month. That day is 31, 30 (months 04, 06, 09, 11) or 28/29 for month 02. February has 29 days when the BCD year is a multiple of four, and year 00 counts as a multiple of four. Month 12 returns to 01 and increments the year, and year 99 wraps to 00.
- R6: Address map: 0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 weekday, 0x04 date, 0x05 month, 0x06 year, 0x07/0x08/0x09 alarm minute/hour/date, 0x0E flags, 0x0F control byte A, 0x10 control byte B. Bits above each field width read 0: 7 bits for seconds, minutes, weekday and alarm minute; 6 for hours, date, alarm hour and alarm date; 5 for month. Control byte A stores all 8 bits. Control byte B stores only bits 3 and 5, so its hour-format bit 1 always reads 0. Unmapped addresses read 0x00.
- R7: Flag bits are: bit 0 power-on, bit 2 alarm, bit 3 timer (always 0), bit 4 update. Writing 0 to a flag clears it and writing 1 leaves it unchanged. Only reset sets the power-on flag.
- R8: The update flag is set on every seconds advance. If a clearing write lands in the same cycle as the advance, the flag ends up set.
- R9: When the minute rolls over and the new minute, hour and date all equal the alarm bytes, the alarm flag is set in that same cycle. A mismatch in any one of them leaves the flag clear. An alarm flag that software clears later in the same minute stays clear.
- R10: irq_n is low exactly when (alarm flag and control B bit 3) or (update flag and control B bit 5).
- R11: A read with reg_first high returns live values and, at the clock edge, captures all seven time bytes. Reads of addresses 0x00 to 0x06 with reg_first low return that capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timekeeping clock, divided down to one-second steps |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe; reg_wdata goes to reg_addr on the clock edge |
| reg_rd | input | 1 | Read strobe; together with reg_first it captures the time bytes |
| reg_first | input | 1 | Marks the first byte of a read burst; selects live time for reads |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two pairs of events can fall in the same clock cycle. In the first pair, the once-per-second advance meets a software write to the flag register. The bench restarts the divider with a seconds write and then counts edges, so that a write of 0x00 to the flag register lands on exactly the advancing edge. The flag register must then read 0x10, with the update flag kept. In the second pair, the advance carries a minute while a burst read is half done. The first byte is captured one edge before the rollover, and the later bytes must still show the pre-carry minute until a new burst starts.

// File: rtl/rtcal_pkg.sv
`timescale 1ns/1ps
package rtcal_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_SEC   = 5'h00;
  localparam logic [ADDR_W-1:0] A_MIN   = 5'h01;
  localparam logic [ADDR_W-1:0] A_HOUR  = 5'h02;
  localparam logic [ADDR_W-1:0] A_WDAY  = 5'h03;
  localparam logic [ADDR_W-1:0] A_DATE  = 5'h04;
  localparam logic [ADDR_W-1:0] A_MON   = 5'h05;
  localparam logic [ADDR_W-1:0] A_YEAR  = 5'h06;
  localparam logic [ADDR_W-1:0] A_AMIN  = 5'h07;
  localparam logic [ADDR_W-1:0] A_AHOUR = 5'h08;
  localparam logic [ADDR_W-1:0] A_ADATE = 5'h09;
  localparam logic [ADDR_W-1:0] A_FLAGS = 5'h0E;
  localparam logic [ADDR_W-1:0] A_CTLA  = 5'h0F;
  localparam logic [ADDR_W-1:0] A_CTLB  = 5'h10;

  // flag and enable bit positions, decoded by software
  localparam int FL_POR = 0;
  localparam int FL_ALM = 2;
  localparam int FL_UPD = 4;
  localparam int EN_ALM = 3;
  localparam int EN_UPD = 5;

  typedef struct packed {
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] date;
    logic [6:0] wday;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  localparam cal_t CAL_RST = '{year: 8'h00, mon: 5'h01, date: 6'h01,
                               wday: 7'h01, hour: 6'h00, min: 7'h00,
                               sec: 7'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] mon,
                                          input logic [7:0] year);
    logic leap;
    leap = year[4] ? (year[3:0] == 4'h2 || year[3:0] == 4'h6)
                   : (year[3:0] == 4'h0 || year[3:0] == 4'h4 ||
                      year[3:0] == 4'h8);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtcal_presc.sv
`timescale 1ns/1ps
module rtcal_presc #(
  parameter int TICKS = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    tick    = at_last & ~restart;
    if (restart || at_last) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtcal_count.sv
`timescale 1ns/1ps
module rtcal_count
  import rtcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output cal_t              cur,
  output cal_t              nxt,
  output logic              min_roll
);
  logic load;

  always_comb begin
    nxt      = cur;
    min_roll = 1'b0;
    if (tick) begin
      if (cur.sec == 7'h59) begin
        nxt.sec  = 7'h00;
        min_roll = 1'b1;
        if (cur.min == 7'h59) begin
          nxt.min = 7'h00;
          if (cur.hour == 6'h23) begin
            nxt.hour = 6'h00;
            nxt.wday = {cur.wday[5:0], cur.wday[6]};
            if (cur.date == last_day(cur.mon, cur.year)) begin
              nxt.date = 6'h01;
              if (cur.mon == 5'h12) begin
                nxt.mon  = 5'h01;
                nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
              end else begin
                nxt.mon = 5'(bcd_inc({3'b000, cur.mon}));
              end
            end else begin
              nxt.date = 6'(bcd_inc({2'b00, cur.date}));
            end
          end else begin
            nxt.hour = 6'(bcd_inc({2'b00, cur.hour}));
          end
        end else begin
          nxt.min = 7'(bcd_inc({1'b0, cur.min}));
        end
      end else begin
        nxt.sec = 7'(bcd_inc({1'b0, cur.sec}));
      end
    end
    if (wr) begin
      case (addr)
        A_SEC:   nxt.sec  = wdata[6:0];
        A_MIN:   nxt.min  = wdata[6:0];
        A_HOUR:  nxt.hour = wdata[5:0];
        A_WDAY:  nxt.wday = wdata[6:0];
        A_DATE:  nxt.date = wdata[5:0];
        A_MON:   nxt.mon  = wdata[4:0];
        A_YEAR:  nxt.year = wdata;
        default: ;
      endcase
    end
    load = tick | wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= CAL_RST;
    else if (load) cur <= nxt;
  end
endmodule

// File: rtl/rtcal_alarm.sv
`timescale 1ns/1ps
module rtcal_alarm
  import rtcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [6:0]        wdata,
  input  logic              eval,
  input  logic [6:0]        cand_min,
  input  logic [5:0]        cand_hour,
  input  logic [5:0]        cand_date,
  output logic [6:0]        al_min,
  output logic [5:0]        al_hour,
  output logic [5:0]        al_date,
  output logic              hit
);
  logic [6:0] min_d;
  logic [5:0] hour_d, date_d;
  logic       load;

  always_comb begin
    min_d  = al_min;
    hour_d = al_hour;
    date_d = al_date;
    load   = 1'b0;
    if (wr) begin
      case (addr)
        A_AMIN:  begin min_d  = wdata;      load = 1'b1; end
        A_AHOUR: begin hour_d = wdata[5:0]; load = 1'b1; end
        A_ADATE: begin date_d = wdata[5:0]; load = 1'b1; end
        default: ;
      endcase
    end
    hit = eval && (cand_min == al_min) && (cand_hour == al_hour) &&
          (cand_date == al_date);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_min  <= '0;
      al_hour <= '0;
      al_date <= '0;
    end else if (load) begin
      al_min  <= min_d;
      al_hour <= hour_d;
      al_date <= date_d;
    end
  end
endmodule

// File: rtl/rtcal_flags.sv
`timescale 1ns/1ps
module rtcal_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_flags,
  input  logic keep_por,
  input  logic keep_alm,
  input  logic keep_upd,
  input  logic set_alm,
  input  logic set_upd,
  input  logic wr_ctl,
  input  logic aie_in,
  input  logic uie_in,
  output logic por,
  output logic alm,
  output logic upd,
  output logic aie,
  output logic uie,
  output logic irq_n
);
  logic por_d, alm_d, upd_d, aie_d, uie_d;

  always_comb begin
    por_d = por & ~(wr_flags & ~keep_por);
    alm_d = set_alm | (alm & ~(wr_flags & ~keep_alm));
    upd_d = set_upd | (upd & ~(wr_flags & ~keep_upd));
    aie_d = wr_ctl ? aie_in : aie;
    uie_d = wr_ctl ? uie_in : uie;
    irq_n = ~((alm & aie) | (upd & uie));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por <= 1'b1;
      alm <= 1'b0;
      upd <= 1'b0;
      aie <= 1'b0;
      uie <= 1'b0;
    end else begin
      por <= por_d;
      alm <= alm_d;
      upd <= upd_d;
      aie <= aie_d;
      uie <= uie_d;
    end
  end
endmodule

// File: rtl/rtcal_core.sv
`timescale 1ns/1ps
module rtcal_core
  import rtcal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_first,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_n
);
  logic [1:0] rst_sync;
  logic       rst_i;
  logic       sec_tick, min_roll, wr_sec, alm_hit;
  cal_t       cur_time, nxt_time, snap, view;
  logic [6:0] al_min;
  logic [5:0] al_hour, al_date;
  logic       st_por, st_alm, st_upd, en_alm, en_upd;
  logic [7:0] ctla;
  logic       snap_en, ctla_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign wr_sec = reg_wr && (reg_addr == A_SEC);

  rtcal_presc #(.TICKS(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst_n(rst_i), .restart(wr_sec), .tick(sec_tick)
  );

  rtcal_count u_count (
    .clk(clk), .rst_n(rst_i), .tick(sec_tick), .wr(reg_wr),
    .addr(reg_addr), .wdata(reg_wdata), .cur(cur_time), .nxt(nxt_time),
    .min_roll(min_roll)
  );

  rtcal_alarm u_alarm (
    .clk(clk), .rst_n(rst_i), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[6:0]), .eval(min_roll), .cand_min(nxt_time.min),
    .cand_hour(nxt_time.hour), .cand_date(nxt_time.date),
    .al_min(al_min), .al_hour(al_hour), .al_date(al_date), .hit(alm_hit)
  );

  rtcal_flags u_flags (
    .clk(clk), .rst_n(rst_i),
    .wr_flags(reg_wr && (reg_addr == A_FLAGS)),
    .keep_por(reg_wdata[FL_POR]), .keep_alm(reg_wdata[FL_ALM]),
    .keep_upd(reg_wdata[FL_UPD]), .set_alm(alm_hit), .set_upd(sec_tick),
    .wr_ctl(reg_wr && (reg_addr == A_CTLB)),
    .aie_in(reg_wdata[EN_ALM]), .uie_in(reg_wdata[EN_UPD]),
    .por(st_por), .alm(st_alm), .upd(st_upd), .aie(en_alm), .uie(en_upd),
    .irq_n(irq_n)
  );

  // burst capture and plain byte register
  always_comb begin
    snap_en = reg_rd & reg_first;
    ctla_en = reg_wr && (reg_addr == A_CTLA);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      snap <= CAL_RST;
      ctla <= 8'h00;
    end else begin
      if (snap_en) snap <= cur_time;
      if (ctla_en) ctla <= reg_wdata;
    end
  end

  always_comb begin
    view = reg_first ? cur_time : snap;
    case (reg_addr)
      A_SEC:   reg_rdata = {1'b0, view.sec};
      A_MIN:   reg_rdata = {1'b0, view.min};
      A_HOUR:  reg_rdata = {2'b00, view.hour};
      A_WDAY:  reg_rdata = {1'b0, view.wday};
      A_DATE:  reg_rdata = {2'b00, view.date};
      A_MON:   reg_rdata = {3'b000, view.mon};
      A_YEAR:  reg_rdata = view.year;
      A_AMIN:  reg_rdata = {1'b0, al_min};
      A_AHOUR: reg_rdata = {2'b00, al_hour};
      A_ADATE: reg_rdata = {2'b00, al_date};
      A_FLAGS: reg_rdata = {3'b000, st_upd, 1'b0, st_alm, 1'b0, st_por};
      A_CTLA:  reg_rdata = ctla;
      A_CTLB:  reg_rdata = {2'b00, en_upd, 1'b0, en_alm, 3'b000};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtcal_chk.sv
`timescale 1ns/1ps
module rtcal_chk
  import rtcal_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic wr,
  input logic min_roll,
  input logic alm,
  input logic upd,
  input logic por,
  input logic irq_n,
  input cal_t time_v
);
  assert_update_on_tick_R8: assert property (
    @(posedge clk) disable iff (!rst_n) tick |=> upd);

  assert_alarm_on_rollover_R9: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(alm) |-> $past(min_roll));

  assert_hold_without_tick_R2: assert property (
    @(posedge clk) disable iff (!rst_n) (!tick && !wr) |=> $stable(time_v));

  assert_por_never_sets_R7: assert property (
    @(posedge clk) disable iff (!rst_n) !$rose(por));

  assert_minute_carry_R3: assert property (
    @(posedge clk) disable iff (!rst_n) min_roll |=> (time_v.sec == 7'h00));

  assert_irq_idle_R10: assert property (
    @(posedge clk) disable iff (!rst_n) (!alm && !upd) |-> irq_n);
endmodule

bind rtcal_core rtcal_chk u_chk (
  .clk(clk), .rst_n(rst_i), .tick(sec_tick), .wr(reg_wr),
  .min_roll(min_roll), .alm(st_alm), .upd(st_upd), .por(st_por),
  .irq_n(irq_n), .time_v(cur_time)
);

// File: tb/rtcal_core_tb.sv
`timescale 1ns/1ps
module rtcal_core_tb;
  localparam int TPS = 16;

  logic       clk, rst_n, reg_wr, reg_rd, reg_first, irq_n;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  int nchk = 0;
  int nfail = 0;

  rtcal_core #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_first(reg_first), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got,
                     input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #0.5 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic rd_time(output logic [55:0] v);
    logic [7:0] b;
    v = '0;
    for (int i = 0; i < 7; i++) begin
      rd(5'(i), b);
      v = {v[47:0], b};
    end
  endtask

  function automatic logic [55:0] pack(int s, int mi, int h, int wd, int d,
                                       int mo, int y);
    return {bcd(s), bcd(mi), bcd(h), 8'(1 << wd), bcd(d), bcd(mo), bcd(y)};
  endfunction

  // seconds first, so the divider restarts at the first write edge
  task automatic set_time(int s, int mi, int h, int wd, int d, int mo, int y);
    wr(5'h00, bcd(s)); wr(5'h01, bcd(mi)); wr(5'h02, bcd(h));
    wr(5'h03, 8'(1 << wd)); wr(5'h04, bcd(d)); wr(5'h05, bcd(mo));
    wr(5'h06, bcd(y));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [55:0] tv;
    int yrs[6] = '{0, 1, 4, 23, 96, 99};
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_first = 1'b1;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_time(tv); chk("R1 time", tv, {8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
    rd(5'h0E, b); chk("R1 flags", b, 8'h01);
    rd(5'h07, b); chk("R1 alarm min", b, 8'h00);
    rd(5'h10, b); chk("R1 ctl B", b, 8'h00);
    chk("R1 irq_n", irq_n, 1'b1);

    // R7 flag write semantics
    wr(5'h0E, 8'hFF); rd(5'h0E, b); chk("R7 write ones keeps", b, 8'h01);
    wr(5'h0E, 8'hFE); rd(5'h0E, b); chk("R7 clear power-on", b, 8'h00);
    wr(5'h0E, 8'hFF); rd(5'h0E, b); chk("R7 power-on not set by write", b, 8'h00);
    // R6 map and masks
    wr(5'h0F, 8'hA5); rd(5'h0F, b); chk("R6 ctl A", b, 8'hA5);
    wr(5'h10, 8'hFF); rd(5'h10, b); chk("R6 ctl B bits", b, 8'h28);
    wr(5'h10, 8'h00);
    wr(5'h04, 8'hC5); rd(5'h04, b); chk("R6 date mask", b, 8'h05);
    rd(5'h0A, b); chk("R6 unmapped", b, 8'h00);

    // R2 R3 R4 R5 sweep of month ends
    for (int yi = 0; yi < 6; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        for (int off = 0; off < 2; off++) begin
          int y, d, wd, ed, em, ey;
          y = yrs[yi];
          d = mdays(m, y) - off;
          wd = (m + y + off) % 7;
          set_time(59, 59, 23, wd, d, m, y);
          repeat (TPS - 7) @(posedge clk);
          @(negedge clk);
          rd_time(tv); chk("R2 no early advance", tv, pack(59, 59, 23, wd, d, m, y));
          @(posedge clk); @(negedge clk);
          ed = d + 1; em = m; ey = y;
          if (d == mdays(m, y)) begin
            ed = 1; em = m + 1;
            if (em == 13) begin em = 1; ey = (y + 1) % 100; end
          end
          rd_time(tv);
          chk("R5 R4 R3 midnight carry", tv, pack(0, 0, 0, (wd + 1) % 7, ed, em, ey));
        end
      end
    end

    // R9 R10 alarm hit, clear, no re-arm, periodic seconds
    wr(5'h07, 8'h00); wr(5'h08, 8'h13); wr(5'h09, 8'h15);
    rd(5'h08, b); chk("R6 alarm hour readback", b, 8'h13);
    wr(5'h10, 8'h08);
    set_time(59, 59, 12, 2, 15, 6, 24);
    wr(5'h0E, 8'h00);
    repeat (TPS - 8) @(posedge clk);
    @(negedge clk);
    chk("R10 irq idle", irq_n, 1'b1);
    @(posedge clk); @(negedge clk);
    rd(5'h0E, b); chk("R9 alarm and update set", b, 8'h14);
    chk("R10 irq on alarm", irq_n, 1'b0);
    wr(5'h0E, 8'hFB); rd(5'h0E, b); chk("R7 clear alarm only", b, 8'h10);
    chk("R10 irq off, update not enabled", irq_n, 1'b1);
    wr(5'h10, 8'h28); chk("R10 irq on update", irq_n, 1'b0);
    wr(5'h0E, 8'h00); chk("R10 irq released", irq_n, 1'b1);
    repeat (3 * TPS - 3) @(posedge clk);
    @(negedge clk);
    rd(5'h00, b); chk("R2 periodic seconds", b, 8'h03);
    rd(5'h0E, b); chk("R9 no re-arm in minute", b[2], 1'b0);
    chk("R8 update set each second", b[4], 1'b1);

    // R9 mismatch on date
    wr(5'h10, 8'h08);
    set_time(59, 59, 12, 2, 14, 6, 24);
    wr(5'h0E, 8'h00);
    repeat (TPS - 8) @(posedge clk);
    @(posedge clk); @(negedge clk);
    rd(5'h0E, b); chk("R9 date mismatch", b, 8'h10);
    chk("R10 update without enable", irq_n, 1'b1);

    // R8 clear write on the advancing edge
    set_time(10, 5, 8, 1, 3, 3, 30);
    repeat (TPS - 7) @(posedge clk);
    @(negedge clk);
    wr(5'h0E, 8'h00);
    rd(5'h0E, b); chk("R8 set wins over clear", b, 8'h10);
    wr(5'h0E, 8'h00); rd(5'h0E, b); chk("R8 later clear", b, 8'h00);

    // R11 burst capture across a minute carry
    set_time(59, 59, 12, 4, 10, 7, 41);
    repeat (TPS - 8) @(posedge clk);
    @(negedge clk);
    reg_first = 1'b1; rd(5'h00, b); reg_rd = 1'b1;
    chk("R11 first byte live", b, 8'h59);
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0; reg_first = 1'b0;
    rd(5'h01, b); chk("R11 captured minute", b, 8'h59);
    @(posedge clk); @(negedge clk);
    rd(5'h01, b); chk("R11 capture survives carry", b, 8'h59);
    rd(5'h02, b); chk("R11 captured hour", b, 8'h12);
    reg_first = 1'b1;
    rd(5'h01, b); chk("R11 live after new burst", b, 8'h00);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule